// File: doc/BRIEF.md
# Dual Prescaled Down-Counter Timer

The block holds two 8-bit down-counting timers. Each has its own 6-bit divider ahead of it, called the prescaler. A timer loads a start value and decrements by one on each divider output pulse. When it finishes a count it raises a one-cycle interrupt request. After that it either halts or reloads and counts again.

The first timer always counts the core clock. The second timer has several count sources:
- the core clock divided by four;
- the rising edges of an external input;
- the core clock divided by four, started by an external edge, with or without restart on later edges;
- the core clock divided by four, gated by the external input level;
- the completions of the first timer, which cascades the two timers.

Software uses a plain register port. It writes load values, prescale values and control bits. It reads the live count combinationally, and a read never changes the count. There is no streaming data path, so no port has valid/ready handshaking. Every input is sampled on the rising clock edge and every output is a plain level.

Top module: `dual_tick_timer`

## Requirements
- R1: The prescaler emits one pulse every P enabled source events, where P is the 6-bit prescale field (1..63). A field of 0 means P = 64. The prescaler is cleared only by a restart.
- R2: Each accepted prescaler pulse lowers the count by one. A load value of 0 behaves as 256. The live count reads back at address 0 (first timer) or address 1 (second timer), and reading it has no effect on the count.
- R3: Each completed count (a pulse seen while the count is 1) drives that timer's irq output high for exactly one cycle. The first timer drives irq_t0 and the second drives irq_t1. Both are low after reset.
- R4: Single-pass mode is continuous bit = 0. At completion the count goes to 0 and the timer's run flag clears.
- R5: Continuous mode is continuous bit = 1. At completion the load value is reloaded and counting goes on, so on the first timer the irq period is P·L cycles.
- R6: Writing the control register with a run bit of 0 freezes that timer's count. Writing run = 1 with restart = 0 resumes from the frozen count and keeps the prescaler phase.
- R7: A restart bit of 1 in a control write loads the load value and clears the prescaler. The first timer's irq then follows P·L edges after the write edge.
- R8: Source select 00 counts the core clock divided by four, with the divider phase cleared on restart. The second timer's irq then follows 4·P·L edges after the write edge.
- R9: Source select 01 counts synchronized rising edges of ext_in. The input passes through a two-flop synchronizer and an edge detector.
- R10: Source select 11 counts the core clock divided by four only while the synchronized ext_in level is high. While the level is low the count holds.
- R11: Source select 10 is trigger mode. A rising ext_in edge loads the count, sets run and clears the prescaler and divider, acting on the third rising clock edge after the input rises. With the retrigger bit at 0, edges are ignored while the timer runs.
- R12: With the retrigger bit at 1, every trigger edge reloads and restarts the timer, even while it is running.
- R13: With the cascade bit set, the second timer's source is the first timer's completion pulse, so its irq period is P0·L0·P1·L1.
- R14: The register map, with control bits in the order written:
  - Write address 0 sets the first timer's load value. Write address 1 sets the second timer's load value.
  - Addresses 2 and 3 take {unused, continuous bit[6], prescale[5:0]} for the first and second timer. Reading them returns only the continuous bit.
  - Address 4 is the control register: cascade[7], retrigger[6], source[5:4], restart1[3], run1[2], restart0[1], run0[0].
  - Reading address 4 returns the run flags in place of the restart bits and returns 0 in the restart positions.
  - After reset every readback is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Combinational read data |
| ext_in | input | 1 | Asynchronous external count/trigger/gate input |
| irq_t0 | output | 1 | First timer completion pulse |
| irq_t1 | output | 1 | Second timer completion pulse |

## Verification
A corrupted count or prescaler phase moves the next irq pulse. The error shows within one timer period, and a count error also shows at once on a read of address 0 or 1. A wrong run flag shows two ways: a count that keeps moving while stopped, or that freezes while running. A synchronizer or trigger fault shifts the irq edge away from the fixed three-cycle latency plus 4·P·L, so measuring the irq cycle exactly against the edge-driving cycle exposes it. A cascade or gate-selection fault changes the second timer's period by whole multiples, which is visible by its second completion.

// File: rtl/dtt_pkg.sv
package dtt_pkg;

  localparam logic [2:0] ADR_LOAD0 = 3'd0;
  localparam logic [2:0] ADR_LOAD1 = 3'd1;
  localparam logic [2:0] ADR_CFG0  = 3'd2;
  localparam logic [2:0] ADR_CFG1  = 3'd3;
  localparam logic [2:0] ADR_CTRL  = 3'd4;

  typedef enum logic [1:0] {
    SRC_DIV4   = 2'b00,
    SRC_EXTCLK = 2'b01,
    SRC_TRIG   = 2'b10,
    SRC_GATE   = 2'b11
  } t1_src_e;

  typedef struct packed {
    logic    cascade;
    logic    retrig;
    t1_src_e src;
    logic    restart1;
    logic    run1;
    logic    restart0;
    logic    run0;
  } ctrl_t;

endpackage

// File: rtl/dtt_sync_edge.sv
module dtt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], ext_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = sync_q[STAGES-1] & ~prev_q;

  // R9: an edge indication never lasts two cycles
  p_edge_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/dtt_prescaler.sv
module dtt_prescaler #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         en_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] pcnt_q;
  logic [W-1:0] reload;

  // a field of 0 wraps to all ones, i.e. divide by 2**W
  assign reload = div_i - 1'b1;
  assign tick_o = en_i && (pcnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)
      pcnt_q <= '0;
    else if (clear_i)
      pcnt_q <= reload;
    else if (en_i)
      pcnt_q <= (pcnt_q == '0) ? reload : pcnt_q - 1'b1;
  end

  // R1: pulses come back to back only when dividing by one
  p_psc_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && div_i != W'(1)) |=> !tick_o);

endmodule

// File: rtl/dtt_counter.sv
module dtt_counter #(
  parameter int CNT_W = 8,
  parameter int PSC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr_i,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic             trig_i,
  input  logic             retrig_i,
  input  logic             src_en_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic [PSC_W-1:0] div_i,
  input  logic             cont_i,
  output logic [CNT_W-1:0] count_o,
  output logic             running_o,
  output logic             irq_o,
  output logic             restart_o
);
  logic [CNT_W-1:0] count_q;
  logic             run_q;
  logic             irq_q;
  logic             psc_tick;
  logic             trig_ok;
  logic             tick_ok;
  logic             at_one;

  assign trig_ok   = trig_i && (retrig_i || !run_q);
  assign restart_o = (cmd_wr_i && restart_i) || trig_ok;
  assign tick_ok   = run_q && psc_tick;
  assign at_one    = (count_q == CNT_W'(1));

  dtt_prescaler #(.W(PSC_W)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (restart_o),
    .en_i    (run_q && src_en_i),
    .div_i   (div_i),
    .tick_o  (psc_tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      run_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= tick_ok && at_one && !restart_o;
      if (restart_o) begin
        count_q <= load_i;
        run_q   <= cmd_wr_i ? run_i : 1'b1;
      end else begin
        if (tick_ok) begin
          if (at_one) begin
            if (cont_i) begin
              count_q <= load_i;
            end else begin
              count_q <= '0;
              run_q   <= 1'b0;
            end
          end else begin
            count_q <= count_q - 1'b1;
          end
        end
        if (cmd_wr_i) run_q <= run_i;
      end
    end
  end

  assign count_o   = count_q;
  assign running_o = run_q;
  assign irq_o     = irq_q;

  // R2: each accepted pulse away from completion lowers the count by exactly one
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_ok && !at_one && !restart_o) |=> count_q == $past(count_q) - 1'b1);

  // R4: a single-pass completion is not followed by a second request
  p_single_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !run_q) |=> !irq_q);

  // R6: a stopped timer keeps its count until restarted
  p_hold_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !restart_o) |=> $stable(count_q));

endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
  import dtt_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PSC_W       = 6,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       ext_in,
  output logic       irq_t0,
  output logic       irq_t1
);
  localparam int NT = 2;

  logic [CNT_W-1:0] load_q  [NT];
  logic [PSC_W-1:0] psc_q   [NT];
  logic [CNT_W-1:0] count_w [NT];
  logic [NT-1:0]    cont_q;
  logic [NT-1:0]    src_en, trig, retrig, run_bit, rst_bit;
  logic [NT-1:0]    irq_w, running_w, restart_w;

  logic    cascade_q, retrig_q;
  t1_src_e src_q;
  ctrl_t   cw;
  logic    ctrl_wr;
  logic    ext_level, ext_rise;
  logic [DIV_W-1:0] qdiv_q;
  logic    div_pulse;

  assign cw      = ctrl_t'(wr_data);
  assign ctrl_wr = wr_en && (wr_addr == ADR_CTRL);
  assign run_bit = {cw.run1, cw.run0};
  assign rst_bit = {cw.restart1, cw.restart0};

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) begin
        load_q[i] <= '0;
        psc_q[i]  <= '0;
      end
      cont_q    <= '0;
      cascade_q <= 1'b0;
      retrig_q  <= 1'b0;
      src_q     <= SRC_DIV4;
    end else if (wr_en) begin
      unique case (wr_addr)
        ADR_LOAD0: load_q[0] <= wr_data[CNT_W-1:0];
        ADR_LOAD1: load_q[1] <= wr_data[CNT_W-1:0];
        ADR_CFG0: begin
          psc_q[0]  <= wr_data[PSC_W-1:0];
          cont_q[0] <= wr_data[PSC_W];
        end
        ADR_CFG1: begin
          psc_q[1]  <= wr_data[PSC_W-1:0];
          cont_q[1] <= wr_data[PSC_W];
        end
        ADR_CTRL: begin
          cascade_q <= cw.cascade;
          retrig_q  <= cw.retrig;
          src_q     <= cw.src;
        end
        default: ;
      endcase
    end
  end

  dtt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_i   (ext_in),
    .level_o (ext_level),
    .rise_o  (ext_rise)
  );

  // divide-by-four phase of the second timer, realigned on each restart
  always_ff @(posedge clk) begin
    if (!rst_n || restart_w[1]) qdiv_q <= '0;
    else                        qdiv_q <= qdiv_q + 1'b1;
  end
  assign div_pulse = &qdiv_q;

  always_comb begin
    src_en[0] = 1'b1;
    trig[0]   = 1'b0;
    retrig[0] = 1'b0;
    retrig[1] = retrig_q;
    trig[1]   = !cascade_q && (src_q == SRC_TRIG) && ext_rise;
    if (cascade_q) begin
      src_en[1] = irq_w[0];
    end else begin
      unique case (src_q)
        SRC_DIV4:   src_en[1] = div_pulse;
        SRC_EXTCLK: src_en[1] = ext_rise;
        SRC_TRIG:   src_en[1] = div_pulse;
        SRC_GATE:   src_en[1] = div_pulse && ext_level;
        default:    src_en[1] = 1'b0;
      endcase
    end
  end

  for (genvar g = 0; g < NT; g++) begin : g_tmr
    dtt_counter #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_wr_i  (ctrl_wr),
      .run_i     (run_bit[g]),
      .restart_i (rst_bit[g]),
      .trig_i    (trig[g]),
      .retrig_i  (retrig[g]),
      .src_en_i  (src_en[g]),
      .load_i    (load_q[g]),
      .div_i     (psc_q[g]),
      .cont_i    (cont_q[g]),
      .count_o   (count_w[g]),
      .running_o (running_w[g]),
      .irq_o     (irq_w[g]),
      .restart_o (restart_w[g])
    );
  end

  always_comb begin
    unique case (rd_addr)
      ADR_LOAD0: rd_data = 8'(count_w[0]);
      ADR_LOAD1: rd_data = 8'(count_w[1]);
      ADR_CFG0:  rd_data = 8'({cont_q[0], {PSC_W{1'b0}}});
      ADR_CFG1:  rd_data = 8'({cont_q[1], {PSC_W{1'b0}}});
      ADR_CTRL:  rd_data = {cascade_q, retrig_q, src_q, 1'b0, running_w[1], 1'b0, running_w[0]};
      default:   rd_data = '0;
    endcase
  end

  assign irq_t0 = irq_w[0];
  assign irq_t1 = irq_w[1];

endmodule

// File: tb/dual_tick_timer_tb.sv
`timescale 1ns/1ps
module dual_tick_timer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic ext_in = 1'b0;
  logic irq_t0, irq_t1;

  int checks = 0, errs = 0;
  int cyc = 0;
  int irq1_n = 0, last1 = 0, prev1 = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_tick_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ext_in(ext_in), .irq_t0(irq_t0), .irq_t1(irq_t1)
  );

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (irq_t1) begin irq1_n++; prev1 = last1; last1 = cyc; end

  function automatic int period(input int p, input int l, input int mul);
    return (p == 0 ? 64 : p) * (l == 0 ? 256 : l) * mul;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    rd_addr = a; #0.1; v = int'(rd_data);
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wait_irq(input bit sel, input int lim, output int n);
    n = 0;
    do begin @(posedge clk); @(negedge clk); n++; end
    while (!(sel ? irq_t1 : irq_t0) && n < lim);
  endtask

  initial begin
    int v, n, p, l, c0, base;
    v = $urandom(32'd2718);
    step(3); rst_n = 1'b1; @(negedge clk);

    // R14 / R3: reset state
    rd(3'd0, v); chk("R14 t0 count after reset", v, 0);
    rd(3'd1, v); chk("R14 t1 count after reset", v, 0);
    rd(3'd4, v); chk("R14 ctrl after reset", v, 0);
    chk("R3 irqs low after reset", int'(irq_t0) + int'(irq_t1), 0);

    // R4 / R7: random single-pass runs on the first timer
    for (int i = 0; i < 4; i++) begin
      p = 1 + int'($urandom % 5); l = 1 + int'($urandom % 8);
      wr(3'd0, 8'(l)); wr(3'd2, 8'(p));
      wr(3'd4, 8'h03);
      wait_irq(0, 2000, n); chk("R7 single-pass irq delay", n, period(p, l, 1));
      step(1); chk("R3 irq one cycle wide", int'(irq_t0), 0);
      rd(3'd0, v); chk("R4 count zero after pass", v, 0);
      rd(3'd4, v); chk("R4 run flag cleared", v & 1, 0);
    end

    // R5: random continuous periods
    for (int i = 0; i < 3; i++) begin
      p = 1 + int'($urandom % 4); l = 1 + int'($urandom % 6);
      wr(3'd0, 8'(l)); wr(3'd2, 8'(64 + p));
      wr(3'd4, 8'h03);
      wait_irq(0, 2000, n); chk("R5 first period", n, period(p, l, 1));
      wait_irq(0, 2000, n); chk("R5 reload period", n, period(p, l, 1));
      wr(3'd4, 8'h00);
    end

    // R2 / R1: encoded extremes
    wr(3'd0, 8'd0); wr(3'd2, 8'd1); wr(3'd4, 8'h03);
    wait_irq(0, 2000, n); chk("R2 load zero means 256", n, 256);
    wr(3'd0, 8'd1); wr(3'd2, 8'd0); wr(3'd4, 8'h03);
    wait_irq(0, 2000, n); chk("R1 prescale zero means 64", n, 64);

    // R2 / R6: live read, stop, resume
    wr(3'd0, 8'd10); wr(3'd2, 8'd4); wr(3'd4, 8'h03);
    step(8);
    rd(3'd0, v); chk("R2 live count", v, 8);
    rd(3'd0, v); chk("R2 read leaves count", v, 8);
    wr(3'd4, 8'h00);
    step(20);
    rd(3'd0, v); chk("R6 count frozen while stopped", v, 8);
    wr(3'd4, 8'h01);
    wait_irq(0, 2000, n); chk("R6 resume keeps count and phase", n, 31);

    // R7: restart in mid count
    wr(3'd0, 8'd5); wr(3'd2, 8'd2); wr(3'd4, 8'h03);
    step(3);
    wr(3'd4, 8'h03);
    rd(3'd0, v); chk("R7 restart reloads", v, 5);
    wait_irq(0, 2000, n); chk("R7 restart delay", n, 10);

    // R8: second timer on divided clock
    for (int i = 0; i < 3; i++) begin
      p = 1 + int'($urandom % 3); l = 1 + int'($urandom % 4);
      wr(3'd1, 8'(l)); wr(3'd3, 8'(p)); wr(3'd4, 8'h0C);
      wait_irq(1, 2000, n); chk("R8 divide-by-four delay", n, period(p, l, 4));
    end

    // R9: external clock edges
    wr(3'd1, 8'd3); wr(3'd3, 8'd1); wr(3'd4, 8'h1C);
    base = irq1_n;
    for (int k = 0; k < 2; k++) begin ext_in = 1'b1; step(4); ext_in = 1'b0; step(4); end
    rd(3'd1, v); chk("R9 two edges counted", v, 1);
    chk("R9 no early irq", irq1_n - base, 0);
    ext_in = 1'b1; step(4); ext_in = 1'b0; step(4);
    chk("R9 third edge completes", irq1_n - base, 1);

    // R10: gate
    wr(3'd1, 8'd4); wr(3'd3, 8'd1); wr(3'd4, 8'h3C);
    base = irq1_n;
    step(30);
    rd(3'd1, v); chk("R10 gate low holds count", v, 4);
    ext_in = 1'b1; step(30); ext_in = 1'b0;
    rd(3'd1, v); chk("R10 gate high counts out", v, 0);
    chk("R10 gate irq", irq1_n - base, 1);
    step(4);

    // R11: non-retriggerable trigger
    wr(3'd1, 8'd5); wr(3'd3, 8'd1); wr(3'd4, 8'h28);
    base = irq1_n; c0 = cyc;
    ext_in = 1'b1; step(5); ext_in = 1'b0; step(3);
    ext_in = 1'b1; step(3); ext_in = 1'b0;
    step(40);
    chk("R11 one irq", irq1_n - base, 1);
    chk("R11 irq cycle ignores second edge", last1 - c0, 23);

    // R12: retriggerable trigger
    wr(3'd4, 8'h68);
    base = irq1_n; c0 = cyc;
    ext_in = 1'b1; step(5); ext_in = 1'b0; step(3);
    ext_in = 1'b1; step(3); ext_in = 1'b0;
    step(45);
    chk("R12 one irq", irq1_n - base, 1);
    chk("R12 second edge restarts", last1 - c0, 31);

    // R13: cascade
    wr(3'd0, 8'd3); wr(3'd2, 8'd65); wr(3'd1, 8'd2); wr(3'd3, 8'd66);
    base = irq1_n;
    wr(3'd4, 8'h8F);
    n = 0;
    while (irq1_n - base < 2 && n < 400) begin step(1); n++; end
    chk("R13 cascade period", last1 - prev1, 12);
    wr(3'd4, 8'h00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule